// File: doc/BRIEF.md
# ARINC 429 Receive Channel with Label-Source Filter

This block recovers 32-bit ARINC 429 words from a line that has already been reduced by external comparators to two digital indications. One indication marks a high line and the other marks a low line. When neither is active, the line is at NULL. The line is sampled on a tick derived from the system clock. Each return-to-zero pulse becomes one bit, and the bits are framed into words. Any word with a bad line condition is thrown away.

An optional source filter compares ARINC bits 9 and 10 against two programmed bits and drops words that do not match. An accepted word is presented to the host as two 16-bit half-words:

- The first half-word carries bits 13 down to 9, then bit 31, bit 30 and bit 32, then bits 1 through 8.
- The second half-word carries bits 29 down to 14.

A ready flag tells the host a word is waiting. The flag clears when the host reads the second half-word.

Top module: `a429_sdi_rx`

## Requirements
- R1: With `line_one_i` high and `line_zero_i` low the line reads ONE, with the reverse it reads ZERO, and with both low it reads NULL. Both high at a sample is invalid and discards the word in progress.
- R2: A ONE or ZERO level held for 2 to TICKS_PER_BIT samples and then followed by NULL yields one bit of that value. A level of a single sample, a level longer than TICKS_PER_BIT samples, or a direct ONE/ZERO swap is invalid and discards the word in progress.
- R3: A word may start only after GAP_BITS*TICKS_PER_BIT consecutive NULL samples, and it completes on its 32nd bit. Such a NULL run in the middle of a word drops the partial word and re-arms framing. A word that starts without that gap is ignored.
- R4: The line is sampled once every DIV_FAST clock cycles while `rx_slow_i` is 0, and once every DIV_SLOW cycles while it is 1.
- R5: `half_lo_o` bits 15..11 hold ARINC bits 13..9, bit 10 holds ARINC bit 31, bit 9 holds ARINC bit 30, bit 8 holds ARINC bit 32, and bits 7..0 hold ARINC bits 1..8. ARINC bit 1 is the first bit received.
- R6: `half_hi_o` bits 15..0 hold ARINC bits 29..14.
- R7: While `sdi_en_i` is 1, a complete word is accepted only if ARINC bit 9 equals `sdi_b9_i` and ARINC bit 10 equals `sdi_b10_i`. A rejected word leaves the outputs and `ready_o` unchanged.
- R8: While `sdi_en_i` is 0, every complete valid word is accepted, whatever its bits 9 and 10 hold.
- R9: After reset the half-words and `ready_o` are 0. `ready_o` rises when a word is accepted. A `rd_hi_i` pulse with no word accepted in the same cycle clears `ready_o` on the next cycle, and the half-words change only on acceptance.
- R10: A newly accepted word replaces an unread one, and `ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_one_i | input | 1 | Comparator output: line at ONE level |
| line_zero_i | input | 1 | Comparator output: line at ZERO level |
| rx_slow_i | input | 1 | Sample divider select: 0 gives DIV_FAST, 1 gives DIV_SLOW |
| sdi_en_i | input | 1 | Enables the bit 9/10 match filter |
| sdi_b9_i | input | 1 | Required value of ARINC bit 9 |
| sdi_b10_i | input | 1 | Required value of ARINC bit 10 |
| rd_hi_i | input | 1 | Host read strobe for the second half-word; clears ready |
| half_lo_o | output | 16 | First half-word of the stored word |
| half_hi_o | output | 16 | Second half-word of the stored word |
| ready_o | output | 1 | A stored word is waiting to be read |

## Verification
The bench uses the default parameters:

- dividers of 10 and 80;
- eight samples per bit;
- a framing gap of three bit times.

At these values a full word takes about 2,600 cycles at the fast rate and about 20,000 at the slow rate, so both divider settings can be run end to end. Because each bit is eight samples long, the bench can place level lengths of 1, 2, 8 and 10 samples exactly. This covers both sides of each pulse-width limit. The three-bit gap is short enough that the bench can test back-to-back words, a mid-word re-arm and a stale unread word, and it can feed a slow-rate line into a fast-sampling receiver to show the divider matters.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int A429_BITS = 32;

  typedef enum logic {ST_HUNT, ST_ARMED} frame_st_e;

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
  } half_pair_t;

  // w[k-1] is ARINC bit k
  function automatic half_pair_t map_word(input logic [A429_BITS-1:0] w);
    half_pair_t p;
    p.lo = {w[12:8], w[30], w[29], w[31],
            w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    p.hi = w[28:13];
    return p;
  endfunction
endpackage

// File: rtl/a429_tick_gen.sv
module a429_tick_gen #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW   = $clog2(DMAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = slow_i ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_line_slicer.sv
module a429_line_slicer #(
  parameter int TICKS_PER_BIT = 8,
  parameter int GAP_BITS      = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic one_i,
  input  logic zero_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic bit_err_o,
  output logic gap_stb_o
);
  localparam int GAP    = GAP_BITS * TICKS_PER_BIT;
  localparam int HW     = $clog2(TICKS_PER_BIT + 1);
  localparam int NW     = $clog2(GAP + 1);
  localparam int MIN_HI = 2;

  logic [SYNC_STAGES-1:0] one_q, zero_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          one_q[g]  <= 1'b0;
          zero_q[g] <= 1'b0;
        end else begin
          one_q[g]  <= one_i;
          zero_q[g] <= zero_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          one_q[g]  <= 1'b0;
          zero_q[g] <= 1'b0;
        end else begin
          one_q[g]  <= one_q[g-1];
          zero_q[g] <= zero_q[g-1];
        end
      end
    end
  end

  logic one_s, zero_s;
  assign one_s  = one_q[SYNC_STAGES-1];
  assign zero_s = zero_q[SYNC_STAGES-1];

  logic          in_lvl_q, cur_q;
  logic [HW-1:0] hi_cnt_q;
  logic [NW-1:0] null_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_lvl_q   <= 1'b0;
      cur_q      <= 1'b0;
      hi_cnt_q   <= '0;
      null_cnt_q <= '0;
      bit_stb_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      bit_err_o  <= 1'b0;
      gap_stb_o  <= 1'b0;
    end else begin
      bit_stb_o <= 1'b0;
      bit_err_o <= 1'b0;
      gap_stb_o <= 1'b0;
      if (tick_i) begin
        if (one_s && zero_s) begin
          bit_err_o  <= 1'b1;
          in_lvl_q   <= 1'b0;
          null_cnt_q <= '0;
        end else if (one_s || zero_s) begin
          null_cnt_q <= '0;
          if (!in_lvl_q) begin
            in_lvl_q <= 1'b1;
            cur_q    <= one_s;
            hi_cnt_q <= HW'(1);
          end else if ((cur_q != one_s) || (hi_cnt_q >= HW'(TICKS_PER_BIT))) begin
            bit_err_o <= 1'b1;  // swap without NULL, or level too long
            in_lvl_q  <= 1'b0;
          end else begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
          end
        end else begin
          if (in_lvl_q) begin
            in_lvl_q   <= 1'b0;
            null_cnt_q <= NW'(1);
            if (hi_cnt_q >= HW'(MIN_HI)) begin
              bit_stb_o <= 1'b1;
              bit_val_o <= cur_q;
            end else begin
              bit_err_o <= 1'b1;  // glitch
            end
          end else if (null_cnt_q < NW'(GAP)) begin
            null_cnt_q <= null_cnt_q + 1'b1;
            if (null_cnt_q == NW'(GAP - 1)) gap_stb_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_word_asm.sv
module a429_word_asm
  import a429_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_stb_i,
  input  logic                 bit_val_i,
  input  logic                 bit_err_i,
  input  logic                 gap_stb_i,
  output logic [A429_BITS-1:0] word_o,
  output logic                 done_o
);
  localparam int CNW = $clog2(A429_BITS);

  frame_st_e            st_q;
  logic [CNW-1:0]       cnt_q;
  logic [A429_BITS-1:0] sh_q;
  logic [A429_BITS-1:0] sh_nxt;

  assign sh_nxt = {bit_val_i, sh_q[A429_BITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      sh_q   <= '0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bit_err_i) begin
        st_q  <= ST_HUNT;
        cnt_q <= '0;
      end else if (gap_stb_i) begin
        st_q  <= ST_ARMED;
        cnt_q <= '0;
      end else if (bit_stb_i && st_q == ST_ARMED) begin
        sh_q <= sh_nxt;
        if (cnt_q == CNW'(A429_BITS - 1)) begin
          done_o <= 1'b1;
          word_o <= sh_nxt;
          st_q   <= ST_HUNT;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/a429_sdi_rx.sv
module a429_sdi_rx
  import a429_rx_pkg::*;
#(
  parameter int DIV_FAST      = 10,
  parameter int DIV_SLOW      = 80,
  parameter int TICKS_PER_BIT = 8,
  parameter int GAP_BITS      = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_one_i,
  input  logic        line_zero_i,
  input  logic        rx_slow_i,
  input  logic        sdi_en_i,
  input  logic        sdi_b9_i,
  input  logic        sdi_b10_i,
  input  logic        rd_hi_i,
  output logic [15:0] half_lo_o,
  output logic [15:0] half_hi_o,
  output logic        ready_o
);
  logic                 tick;
  logic                 bit_stb, bit_val, bit_err, gap_stb;
  logic                 word_done;
  logic [A429_BITS-1:0] word;
  half_pair_t           mapped;
  logic                 sdi_ok, accept;

  a429_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (rx_slow_i),
    .tick_o (tick)
  );

  a429_line_slicer #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .GAP_BITS      (GAP_BITS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_slicer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .one_i     (line_one_i),
    .zero_i    (line_zero_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .bit_err_o (bit_err),
    .gap_stb_o (gap_stb)
  );

  a429_word_asm u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .bit_err_i (bit_err),
    .gap_stb_i (gap_stb),
    .word_o    (word),
    .done_o    (word_done)
  );

  assign mapped = map_word(word);
  assign sdi_ok = !sdi_en_i || ((word[8] == sdi_b9_i) && (word[9] == sdi_b10_i));
  assign accept = word_done && sdi_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_lo_o <= '0;
      half_hi_o <= '0;
      ready_o   <= 1'b0;
    end else if (accept) begin
      half_lo_o <= mapped.lo;
      half_hi_o <= mapped.hi;
      ready_o   <= 1'b1;
    end else if (rd_hi_i) begin
      ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_sdi_rx_chk.sv
module a429_sdi_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        word_done_i,
  input logic [1:0]  w_sdi_i,
  input logic [15:0] w_hi_i,
  input logic        sdi_en_i,
  input logic        sdi_b9_i,
  input logic        sdi_b10_i,
  input logic        rd_hi_i,
  input logic [15:0] half_lo_o,
  input logic [15:0] half_hi_o,
  input logic        ready_o
);
  a_r4_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  a_r9_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !word_done_i) |=> !ready_o);

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done_i |=> ($stable(half_lo_o) && $stable(half_hi_o)));

  a_r7_sdi_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && sdi_en_i && ((w_sdi_i[0] != sdi_b9_i) || (w_sdi_i[1] != sdi_b10_i)))
    |=> ($stable(half_lo_o) && $stable(half_hi_o)));

  a_r8_take_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && !sdi_en_i) |=> (ready_o && half_hi_o == $past(w_hi_i)));
endmodule

bind a429_sdi_rx a429_sdi_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .word_done_i (word_done),
  .w_sdi_i     (word[9:8]),
  .w_hi_i      (word[28:13]),
  .sdi_en_i    (sdi_en_i),
  .sdi_b9_i    (sdi_b9_i),
  .sdi_b10_i   (sdi_b10_i),
  .rd_hi_i     (rd_hi_i),
  .half_lo_o   (half_lo_o),
  .half_hi_o   (half_hi_o),
  .ready_o     (ready_o)
);

// File: tb/a429_sdi_rx_tb.sv
module a429_sdi_rx_tb;
  localparam int TPB   = 8;
  localparam int DIVF  = 10;
  localparam int DIVS  = 80;
  localparam int HI_T  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        one = 1'b0, zero = 1'b0;
  logic        rx_slow = 1'b0, sdi_en = 1'b0, b9 = 1'b0, b10 = 1'b0, rd_hi = 1'b0;
  logic [15:0] lo, hi;
  logic        rdy;

  int checks = 0;
  int fails  = 0;
  int div    = DIVF;
  bit done   = 1'b0;

  logic [15:0] keep_lo, keep_hi;

  always #4 clk = ~clk;

  a429_sdi_rx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_one_i  (one),
    .line_zero_i (zero),
    .rx_slow_i   (rx_slow),
    .sdi_en_i    (sdi_en),
    .sdi_b9_i    (b9),
    .sdi_b10_i   (b10),
    .rd_hi_i     (rd_hi),
    .half_lo_o   (lo),
    .half_hi_o   (hi),
    .ready_o     (rdy)
  );

  function automatic logic [15:0] exp_lo(input logic [31:0] w);
    logic [15:0] r;
    for (int k = 1; k <= 8; k++) r[8-k] = w[k-1];
    for (int k = 9; k <= 13; k++) r[k+2] = w[k-1];
    r[10] = w[30];
    r[9]  = w[29];
    r[8]  = w[31];
    return r;
  endfunction

  function automatic logic [15:0] exp_hi(input logic [31:0] w);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) r[j] = w[13+j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [15:0] elo, input logic [15:0] ehi, input logic erdy);
    chk(lo == elo, {req, " half_lo"}, {16'h0, lo}, {16'h0, elo});
    chk(hi == ehi, {req, " half_hi"}, {16'h0, hi}, {16'h0, ehi});
    chk(rdy == erdy, {req, " ready"}, {31'h0, rdy}, {31'h0, erdy});
  endtask

  task automatic nulls(input int n);
    one = 1'b0; zero = 1'b0;
    repeat (n * div) @(negedge clk);
  endtask

  task automatic level(input logic b, input int n);
    one = b; zero = !b;
    repeat (n * div) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int hl);
    level(b, hl);
    nulls(TPB - HI_T);
  endtask

  task automatic send_bits(input logic [31:0] w, input int from, input int upto, input int hl);
    for (int k = from; k <= upto; k++) send_bit(w[k], hl);
  endtask

  task automatic gap();
    nulls(4 * TPB);
  endtask

  task automatic read_hi();
    @(negedge clk); rd_hi = 1'b1;
    @(negedge clk); rd_hi = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_out("R9 reset", 16'h0, 16'h0, 1'b0);
  endtask

  task automatic t_basic();
    logic [31:0] w = 32'hA5C3_1E69;
    sdi_en = 1'b0;
    gap(); send_bits(w, 0, 31, HI_T); gap();
    chk_out("R5 R6 R8 basic", exp_lo(w), exp_hi(w), 1'b1);
  endtask

  task automatic t_read();
    keep_lo = lo; keep_hi = hi;
    read_hi();
    chk_out("R9 read clears", keep_lo, keep_hi, 1'b0);
  endtask

  task automatic t_sdi();
    logic [31:0] w2 = 32'h3C0F_0355;
    logic [31:0] w3 = w2 ^ 32'h0000_0100;
    logic [31:0] w4 = w2 ^ 32'h0000_0200;
    sdi_en = 1'b1; b9 = w2[8]; b10 = w2[9];
    gap(); send_bits(w2, 0, 31, HI_T); gap();
    chk_out("R7 match kept", exp_lo(w2), exp_hi(w2), 1'b1);
    read_hi();
    send_bits(w3, 0, 31, HI_T); gap();
    chk_out("R7 bit9 mismatch dropped", exp_lo(w2), exp_hi(w2), 1'b0);
    send_bits(w4, 0, 31, HI_T); gap();
    chk_out("R7 bit10 mismatch dropped", exp_lo(w2), exp_hi(w2), 1'b0);
    sdi_en = 1'b0;
    send_bits(w3, 0, 31, HI_T); gap();
    chk_out("R8 decoder off accepts", exp_lo(w3), exp_hi(w3), 1'b1);
    read_hi();
  endtask

  task automatic t_both();
    logic [31:0] w = 32'h1234_ABCD;
    keep_lo = lo; keep_hi = hi;
    gap(); send_bits(w, 0, 11, HI_T);
    one = 1'b1; zero = 1'b1; repeat (HI_T * div) @(negedge clk);
    nulls(TPB - HI_T);
    send_bits(w, 12, 31, HI_T); gap();
    chk_out("R1 both asserted aborts", keep_lo, keep_hi, 1'b0);
    send_bits(w, 0, 31, HI_T); gap();
    chk_out("R1 recovery after abort", exp_lo(w), exp_hi(w), 1'b1);
    read_hi();
  endtask

  task automatic t_widths();
    logic [31:0] w = 32'h0F0F_F0F0;
    logic [31:0] v = 32'h8001_7FFE;
    keep_lo = lo; keep_hi = hi;
    gap(); send_bits(w, 0, 5, HI_T);
    level(1'b1, 1); nulls(TPB - 1);
    send_bits(w, 6, 30, HI_T); gap();
    chk_out("R2 one-sample glitch aborts", keep_lo, keep_hi, 1'b0);
    send_bits(w, 0, 9, HI_T);
    level(1'b0, TPB + 2); nulls(TPB - HI_T);
    send_bits(w, 11, 31, HI_T); gap();
    chk_out("R2 overlong level aborts", keep_lo, keep_hi, 1'b0);
    send_bits(w, 0, 9, HI_T);
    level(1'b1, HI_T); one = 1'b0; zero = 1'b1; repeat (HI_T * div) @(negedge clk);
    nulls(TPB - HI_T);
    send_bits(w, 11, 31, HI_T); gap();
    chk_out("R2 swap without NULL aborts", keep_lo, keep_hi, 1'b0);
    send_bits(v, 0, 31, 2); gap();
    chk_out("R2 minimum level accepted", exp_lo(v), exp_hi(v), 1'b1);
    read_hi();
    send_bits(w, 0, 31, TPB); gap();
    chk_out("R2 maximum level accepted", exp_lo(w), exp_hi(w), 1'b1);
    read_hi();
  endtask

  task automatic t_framing();
    logic [31:0] a = 32'hDEAD_BEEF;
    logic [31:0] b = 32'h7654_3210;
    gap(); send_bits(a, 0, 9, HI_T); gap();
    send_bits(b, 0, 31, HI_T); gap();
    chk_out("R3 mid-word gap re-arms", exp_lo(b), exp_hi(b), 1'b1);
    read_hi();
    send_bits(a, 0, 31, HI_T); send_bits(b, 0, 31, HI_T); gap();
    chk_out("R3 word without gap ignored", exp_lo(a), exp_hi(a), 1'b1);
    read_hi();
  endtask

  task automatic t_overwrite();
    logic [31:0] a = 32'h0BAD_F00D;
    logic [31:0] b = 32'hC0DE_5A5A;
    gap(); send_bits(a, 0, 31, HI_T); gap();
    send_bits(b, 0, 31, HI_T); gap();
    chk_out("R10 unread word replaced", exp_lo(b), exp_hi(b), 1'b1);
    read_hi();
  endtask

  task automatic t_divider();
    logic [31:0] a = 32'h9E37_79B9;
    logic [31:0] b = 32'h2468_ACE1;
    rx_slow = 1'b1; div = DIVS;
    gap(); send_bits(a, 0, 31, HI_T); gap();
    chk_out("R4 slow divider word", exp_lo(a), exp_hi(a), 1'b1);
    read_hi();
    rx_slow = 1'b0;
    gap(); send_bits(b, 0, 31, HI_T); gap();
    chk_out("R4 slow line at fast sampling rejected", exp_lo(a), exp_hi(a), 1'b0);
    div = DIVF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_read();
    t_sdi();
    t_both();
    t_widths();
    t_framing();
    t_overwrite();
    t_divider();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule